// File: doc/BRIEF.md
# Serial Link Self-Test Pattern Engine

This block holds the two self-test engines that sit on either side of a byte-oriented serial link. They work one symbol per byte clock, ahead of line coding. The transmit engine owns the symbol stream whenever its test mode is on. With the test armed but not started, it sends an alternating one-zero fill. Once started, it steps a 9-bit maximal-length LFSR and turns each state into a symbol. The resulting 511-symbol loop covers data, special and violation classes and carries one loop marker, the data symbol with byte 0x00. A read strobe marks the last byte of each loop. A violation request overrides the generator for one byte and sends the loop back to its start.

The receive engine, once its test mode is on, ignores the line until the marker arrives. From then on it steps an identical LFSR and compares every received symbol with the expected one. The results are a per-byte error flag, a ready pulse on the last byte of each loop, and a sticky error flag. Both engines have their own active-low test enable, so one instance can act as either end of a link. A loopback ties the two ends together.

Symbols cross the ports as a 2-bit class and an 8-bit byte. The class codes are 0 for data, 1 for special and 2 for violation. The LFSR is Fibonacci form: next = {s[7:0], s[8]^s[4]}. State s maps to byte s[7:0]. The class is data if s[8]=0, violation if s[8]=1 and s[7]=1, special if s[8]=1 and s[7:6]=01, and data if s[8]=1 and s[7:6]=00. Reset and re-seed put the LFSR at state 0x100, which maps to the marker. State 0x080 is the last state of the loop.

Top module: `link_selftest`

## Requirements
- R1: After synchronous reset `rst`, tx_drive=0, tx_rp_n=1, rx_sync=0, rx_err=0, rx_rdy=0 and rx_err_sticky=0.
- R2: With tx_test_n=0, tx_viol=0 and both tx_ld_now_n and tx_ld_nxt_n high, each clock emits a data symbol that alternates 0x4A, 0xB5, 0x4A, and so on. The first after reset is 0x4A.
- R3: With tx_test_n=0, tx_viol=0 and either load enable low, each clock emits the symbol of the current LFSR state (mapping above) and steps the LFSR. The output repeats every 511 bytes and contains data, special and violation classes. The marker (class 0, byte 0x00) appears exactly once per loop.
- R4: With tx_test_n=0 and tx_viol=1, the emitted symbol is class 2, byte 0x00, and the LFSR reloads 0x100. The first running byte afterwards is the marker.
- R5: tx_rp_n goes low for exactly the byte emitted from state 0x080, the byte just before the marker, and is high for every other byte.
- R6: With rx_test_n=0 and no lock, every input other than the marker leaves rx_sync, rx_err and rx_rdy low. rx_sync rises on the clock after the marker is present on the input.
- R7: While locked, rx_err is high for one clock after each input symbol that differs from the expected one, and low after each symbol that matches.
- R8: While locked, rx_rdy is high for the clock after the last byte of a loop (state 0x080) and low otherwise.
- R9: After a mismatch the checker keeps stepping and stays locked. Later correct bytes give rx_err=0 and rx_rdy stays aligned to the loop.
- R10: rx_err_sticky sets on any mismatch and holds while rx_test_n=0. rx_test_n=1 clears it and drops the lock.
- R11: With tx_test_n=1 the transmitter emits the idle fill (class 1, byte 0xBC) with tx_drive=0 and tx_rp_n=1, and tx_viol has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_test_n | input | 1 | Transmit self-test enable, active low |
| tx_ld_now_n | input | 1 | Load enable, active low; either low starts the sequence |
| tx_ld_nxt_n | input | 1 | Second load enable, active low |
| tx_viol | input | 1 | Force violation symbol and re-seed |
| tx_sym_cls | output | 2 | Emitted symbol class |
| tx_sym_byte | output | 8 | Emitted symbol byte |
| tx_drive | output | 1 | High while the generator owns the symbol stream |
| tx_rp_n | output | 1 | Read strobe, low on the last byte of a loop |
| rx_test_n | input | 1 | Receive self-test enable, active low |
| rx_sym_cls | input | 2 | Received symbol class |
| rx_sym_byte | input | 8 | Received symbol byte |
| rx_sync | output | 1 | Checker locked to the loop |
| rx_err | output | 1 | Previous byte mismatched |
| rx_rdy | output | 1 | Previous byte was the last of a loop |
| rx_err_sticky | output | 1 | Any mismatch since the test was armed |

## Verification
The properties take for granted that every input is a known level that changes only between rising clock edges. They also assume the received class is never code 3. The restart property assumes a violation byte is followed by a running byte and not by another mode. The bench drives all inputs one nanosecond after the rising edge and only from the defined class codes. It inserts violations only between a running stretch and a running stretch, or from the alternating fill into running, so every transition it makes is one the properties describe.

// File: rtl/lst_pkg.sv
package lst_pkg;

    localparam int BYTE_W = 8;
    localparam int LFSR_W = BYTE_W + 1;
    localparam int FB_TAP = 5;

    typedef enum logic [1:0] {
        SYM_DATA = 2'd0,
        SYM_SPEC = 2'd1,
        SYM_VIOL = 2'd2
    } sym_cls_e;

    typedef struct packed {
        sym_cls_e              cls;
        logic [BYTE_W-1:0]     val;
    } sym_t;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        TXM_IDLE,
        TXM_VIOL,
        TXM_RUN,
        TXM_ALT
    } tx_mode_e;

    typedef enum logic {
        RXP_HUNT,
        RXP_CHECK
    } rx_phase_e;

    // Loop start (maps to the marker) and the state just before it.
    localparam lfsr_t SEED    = {1'b1, {(LFSR_W-1){1'b0}}};
    localparam lfsr_t LAST_ST = {2'b01, {(LFSR_W-2){1'b0}}};

    localparam sym_t MARKER    = '{cls: SYM_DATA, val: '0};
    localparam sym_t ALT_LO    = '{cls: SYM_DATA, val: BYTE_W'(8'h4A)};
    localparam sym_t ALT_HI    = '{cls: SYM_DATA, val: BYTE_W'(8'hB5)};
    localparam sym_t IDLE_FILL = '{cls: SYM_SPEC, val: BYTE_W'(8'hBC)};
    localparam sym_t VIOL_FILL = '{cls: SYM_VIOL, val: '0};

    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[FB_TAP-1]};
    endfunction

    function automatic sym_t sym_of(input lfsr_t s);
        sym_t r;
        r.val = s[BYTE_W-1:0];
        if (!s[LFSR_W-1])       r.cls = SYM_DATA;
        else if (s[BYTE_W-1])   r.cls = SYM_VIOL;
        else if (s[BYTE_W-2])   r.cls = SYM_SPEC;
        else                    r.cls = SYM_DATA;
        return r;
    endfunction

endpackage

// File: rtl/lst_sym_map.sv
module lst_sym_map
    import lst_pkg::*;
(
    input  lfsr_t state,
    output sym_t  sym
);
    assign sym = sym_of(state);
endmodule

// File: rtl/lst_tx_gen.sv
module lst_tx_gen
    import lst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic test_n,
    input  logic ld_now_n,
    input  logic ld_nxt_n,
    input  logic force_viol,
    output sym_t sym_q,
    output logic drive_q,
    output logic rd_strobe_n_q
);
    lfsr_t    st;
    logic     alt_ph;
    sym_t     seq_sym;
    tx_mode_e mode;

    lst_sym_map u_map (.state(st), .sym(seq_sym));

    always_comb begin
        if (test_n)                      mode = TXM_IDLE;
        else if (force_viol)             mode = TXM_VIOL;
        else if (!ld_now_n || !ld_nxt_n) mode = TXM_RUN;
        else                             mode = TXM_ALT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= SEED;
            alt_ph        <= 1'b0;
            sym_q         <= IDLE_FILL;
            drive_q       <= 1'b0;
            rd_strobe_n_q <= 1'b1;
        end else begin
            case (mode)
                TXM_IDLE: begin
                    sym_q         <= IDLE_FILL;
                    drive_q       <= 1'b0;
                    rd_strobe_n_q <= 1'b1;
                end
                TXM_VIOL: begin
                    sym_q         <= VIOL_FILL;
                    st            <= SEED;
                    drive_q       <= 1'b1;
                    rd_strobe_n_q <= 1'b1;
                end
                TXM_RUN: begin
                    sym_q         <= seq_sym;
                    st            <= lfsr_next(st);
                    drive_q       <= 1'b1;
                    rd_strobe_n_q <= (st != LAST_ST);
                end
                default: begin
                    sym_q         <= alt_ph ? ALT_HI : ALT_LO;
                    alt_ph        <= ~alt_ph;
                    drive_q       <= 1'b1;
                    rd_strobe_n_q <= 1'b1;
                end
            endcase
        end
    end

    AST_VIOL_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (mode == TXM_VIOL) ##1 (mode == TXM_RUN) |=> (sym_q == MARKER))
        else $error("restart after violation lost"); // R4

    AST_ALT_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (mode == TXM_ALT) ##1 (mode == TXM_ALT) |=> (sym_q.val != $past(sym_q.val)))
        else $error("fill did not alternate"); // R2

    AST_STROBE_BEFORE_MARKER: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe_n_q && mode == TXM_RUN) |=> (sym_q == MARKER))
        else $error("strobe not on last byte"); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        test_n |=> (!drive_q && rd_strobe_n_q && sym_q == IDLE_FILL))
        else $error("idle output wrong"); // R11

endmodule

// File: rtl/lst_rx_chk.sv
module lst_rx_chk
    import lst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic test_n,
    input  sym_t sym_in,
    output logic sync_q,
    output logic err_q,
    output logic rdy_q,
    output logic sticky_q
);
    rx_phase_e phase;
    lfsr_t     st;
    sym_t      exp_sym;
    logic      miss;

    lst_sym_map u_map (.state(st), .sym(exp_sym));

    assign miss   = (sym_in != exp_sym);
    assign sync_q = (phase == RXP_CHECK);

    always_ff @(posedge clk) begin
        if (rst || test_n) begin
            phase    <= RXP_HUNT;
            st       <= SEED;
            err_q    <= 1'b0;
            rdy_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else if (phase == RXP_HUNT) begin
            err_q <= 1'b0;
            rdy_q <= 1'b0;
            if (sym_in == MARKER) begin
                phase <= RXP_CHECK;
                st    <= lfsr_next(SEED);
            end
        end else begin
            err_q    <= miss;
            sticky_q <= sticky_q | miss;
            rdy_q    <= (st == LAST_ST);
            st       <= lfsr_next(st);
        end
    end

    AST_RDY_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        rdy_q |-> sync_q)
        else $error("ready outside lock"); // R8

    AST_ERR_STICKS: assert property (@(posedge clk) disable iff (rst)
        err_q |-> sticky_q)
        else $error("error not sticky"); // R7

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && !test_n) |=> sticky_q)
        else $error("sticky lost"); // R10

    AST_NO_REHUNT: assert property (@(posedge clk) disable iff (rst)
        (sync_q && !test_n) |=> sync_q)
        else $error("lock dropped"); // R9

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sync_q |-> (!err_q && !rdy_q))
        else $error("flags while hunting"); // R6

    AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (rst)
        (!sync_q && !test_n && sym_in == MARKER) |=> sync_q)
        else $error("marker missed"); // R6

endmodule

// File: rtl/link_selftest.sv
module link_selftest
    import lst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_test_n,
    input  logic              tx_ld_now_n,
    input  logic              tx_ld_nxt_n,
    input  logic              tx_viol,
    output logic [1:0]        tx_sym_cls,
    output logic [BYTE_W-1:0] tx_sym_byte,
    output logic              tx_drive,
    output logic              tx_rp_n,
    input  logic              rx_test_n,
    input  logic [1:0]        rx_sym_cls,
    input  logic [BYTE_W-1:0] rx_sym_byte,
    output logic              rx_sync,
    output logic              rx_err,
    output logic              rx_rdy,
    output logic              rx_err_sticky
);
    sym_t tx_s;
    sym_t rx_s;

    assign tx_sym_cls  = tx_s.cls;
    assign tx_sym_byte = tx_s.val;
    assign rx_s.cls    = sym_cls_e'(rx_sym_cls);
    assign rx_s.val    = rx_sym_byte;

    lst_tx_gen u_tx (
        .clk          (clk),
        .rst          (rst),
        .test_n       (tx_test_n),
        .ld_now_n     (tx_ld_now_n),
        .ld_nxt_n     (tx_ld_nxt_n),
        .force_viol   (tx_viol),
        .sym_q        (tx_s),
        .drive_q      (tx_drive),
        .rd_strobe_n_q(tx_rp_n)
    );

    lst_rx_chk u_rx (
        .clk     (clk),
        .rst     (rst),
        .test_n  (rx_test_n),
        .sym_in  (rx_s),
        .sync_q  (rx_sync),
        .err_q   (rx_err),
        .rdy_q   (rx_rdy),
        .sticky_q(rx_err_sticky)
    );

endmodule

// File: tb/sim_link_selftest.sv
module sim_link_selftest;

    logic       clk = 1'b0;
    logic       rst;
    logic       tx_test_n, tx_ld_now_n, tx_ld_nxt_n, tx_viol;
    logic [1:0] tx_sym_cls;
    logic [7:0] tx_sym_byte;
    logic       tx_drive, tx_rp_n;
    logic       rx_test_n;
    logic [1:0] rx_sym_cls;
    logic [7:0] rx_sym_byte;
    logic       rx_sync, rx_err, rx_rdy, rx_err_sticky;

    logic       loopback;
    logic [7:0] corrupt;
    logic [1:0] drv_cls;
    logic [7:0] drv_byte;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign rx_sym_cls  = loopback ? tx_sym_cls : drv_cls;
    assign rx_sym_byte = loopback ? (tx_sym_byte ^ corrupt) : drv_byte;

    link_selftest u0 (
        .clk(clk), .rst(rst),
        .tx_test_n(tx_test_n), .tx_ld_now_n(tx_ld_now_n), .tx_ld_nxt_n(tx_ld_nxt_n),
        .tx_viol(tx_viol), .tx_sym_cls(tx_sym_cls), .tx_sym_byte(tx_sym_byte),
        .tx_drive(tx_drive), .tx_rp_n(tx_rp_n),
        .rx_test_n(rx_test_n), .rx_sym_cls(rx_sym_cls), .rx_sym_byte(rx_sym_byte),
        .rx_sync(rx_sync), .rx_err(rx_err), .rx_rdy(rx_rdy), .rx_err_sticky(rx_err_sticky)
    );

    function automatic logic [8:0] m_next(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    function automatic logic [9:0] m_sym(input logic [8:0] s);
        logic [1:0] c;
        if (!s[8])     c = 2'd0;
        else if (s[7]) c = 2'd2;
        else if (s[6]) c = 2'd1;
        else           c = 2'd0;
        return {c, s[7:0]};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1; tx_test_n = 1'b1; rx_test_n = 1'b1;
        tx_ld_now_n = 1'b1; tx_ld_nxt_n = 1'b1; tx_viol = 1'b0;
        loopback = 1'b0; corrupt = 8'h00; drv_cls = 2'd1; drv_byte = 8'h00;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(tx_drive == 1'b0, "R1 tx_drive", tx_drive, 0);
        chk(tx_rp_n == 1'b1, "R1 tx_rp_n", tx_rp_n, 1);
        chk({rx_sync, rx_err, rx_rdy, rx_err_sticky} == 4'b0, "R1 rx flags",
            {rx_sync, rx_err, rx_rdy, rx_err_sticky}, 0);
        chk({tx_sym_cls, tx_sym_byte} == {2'd1, 8'hBC}, "R11 idle fill",
            {tx_sym_cls, tx_sym_byte}, {2'd1, 8'hBC});
    endtask

    task automatic t_alt;
        tx_test_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk({tx_sym_cls, tx_sym_byte} == {2'd0, (i % 2) ? 8'hB5 : 8'h4A}, "R2 alternating fill",
                {tx_sym_cls, tx_sym_byte}, {2'd0, (i % 2) ? 8'hB5 : 8'h4A});
            chk(tx_drive && tx_rp_n, "R2 drive/strobe", {tx_drive, tx_rp_n}, 2'b11);
        end
    endtask

    task automatic t_hunt;
        logic [9:0] junk [5];
        junk[0] = {2'd0, 8'h4A}; junk[1] = {2'd2, 8'h00}; junk[2] = {2'd1, 8'h00};
        junk[3] = {2'd0, 8'h01}; junk[4] = {2'd0, 8'h80};
        rx_test_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            {drv_cls, drv_byte} = junk[i];
            step();
            chk({rx_sync, rx_err, rx_rdy} == 3'b0, "R6 ignored while hunting",
                {rx_sync, rx_err, rx_rdy}, 0);
        end
        {drv_cls, drv_byte} = 10'h000;
        step();
        chk(rx_sync == 1'b1, "R6 lock on marker", rx_sync, 1);
        rx_test_n = 1'b1;
        step();
        chk(rx_sync == 1'b0, "R10 disarm drops lock", rx_sync, 0);
    endtask

    task automatic t_loop;
        logic [8:0] m;
        logic       prev_last;
        int         mk_cnt, mk_first, mk_second;
        int         seen_d, seen_s, seen_v, rp_cnt, rdy_cnt;
        mk_cnt = 0; mk_first = -1; mk_second = -1;
        seen_d = 0; seen_s = 0; seen_v = 0; rp_cnt = 0; rdy_cnt = 0;
        rx_test_n = 1'b0; loopback = 1'b1; tx_viol = 1'b1;
        step();
        chk({tx_sym_cls, tx_sym_byte} == {2'd2, 8'h00}, "R4 violation symbol",
            {tx_sym_cls, tx_sym_byte}, {2'd2, 8'h00});
        tx_viol = 1'b0; tx_ld_now_n = 1'b0;
        step();
        chk({tx_sym_cls, tx_sym_byte} == 10'h000, "R4 restart at marker",
            {tx_sym_cls, tx_sym_byte}, 0);
        chk(rx_sync == 1'b0, "R6 no lock before marker", rx_sync, 0);
        m = m_next(9'h100);
        for (int i = 0; i < 1100; i++) begin
            if (i == 300) begin
                tx_ld_now_n = 1'b1; tx_ld_nxt_n = 1'b0;
            end
            prev_last = !tx_rp_n;
            step();
            chk({tx_sym_cls, tx_sym_byte} == m_sym(m), "R3 sequence symbol",
                {tx_sym_cls, tx_sym_byte}, m_sym(m));
            chk(tx_rp_n == (m != 9'h080), "R5 read strobe", tx_rp_n, (m != 9'h080));
            chk(rx_sync == 1'b1, "R6 locked", rx_sync, 1);
            chk(rx_err == 1'b0, "R7 match gives no error", rx_err, 0);
            chk(rx_rdy == prev_last, "R8 ready on last byte", rx_rdy, prev_last);
            if ({tx_sym_cls, tx_sym_byte} == 10'h000) begin
                mk_cnt++;
                if (mk_first < 0) mk_first = i; else mk_second = i;
            end
            if (i < 511) begin
                if (tx_sym_cls == 2'd0) seen_d++;
                if (tx_sym_cls == 2'd1) seen_s++;
                if (tx_sym_cls == 2'd2) seen_v++;
            end
            if (!tx_rp_n) rp_cnt++;
            if (rx_rdy) rdy_cnt++;
            m = m_next(m);
        end
        chk(mk_cnt == 2, "R3 markers in 1100 bytes", mk_cnt, 2);
        chk(mk_second - mk_first == 511, "R3 loop length", mk_second - mk_first, 511);
        chk(seen_d > 0 && seen_s > 0 && seen_v > 0, "R3 all classes present",
            {seen_d[7:0], seen_s[7:0], seen_v[7:0]}, 1);
        chk(rp_cnt == 2, "R5 strobe pulses", rp_cnt, 2);
        chk(rdy_cnt == 2, "R8 ready pulses", rdy_cnt, 2);
    endtask

    task automatic t_corrupt;
        logic prev_last;
        int   rdy_cnt;
        bit   found;
        rdy_cnt = 0;
        corrupt = 8'h01;
        step();
        chk(rx_err == 1'b1, "R7 mismatch flagged", rx_err, 1);
        chk(rx_err_sticky == 1'b1, "R10 sticky set", rx_err_sticky, 1);
        corrupt = 8'h00;
        for (int i = 0; i < 600; i++) begin
            prev_last = !tx_rp_n;
            step();
            chk(rx_err == 1'b0, "R9 later bytes match", rx_err, 0);
            chk(rx_sync == 1'b1, "R9 lock kept", rx_sync, 1);
            chk(rx_rdy == prev_last, "R9 ready still aligned", rx_rdy, prev_last);
            chk(rx_err_sticky == 1'b1, "R10 sticky holds", rx_err_sticky, 1);
            if (rx_rdy) rdy_cnt++;
        end
        chk(rdy_cnt >= 1, "R9 ready pulses continue", rdy_cnt, 1);
        rx_test_n = 1'b1;
        step();
        chk({rx_sync, rx_err, rx_err_sticky} == 3'b0, "R10 disarm clears",
            {rx_sync, rx_err, rx_err_sticky}, 0);
        rx_test_n = 1'b0;
        found = 1'b0;
        for (int i = 0; i < 600 && !found; i++) begin
            step();
            if (rx_sync) found = 1'b1;
        end
        chk(found, "R6 relock on next marker", found, 1);
        step();
        chk(rx_err == 1'b0 && rx_err_sticky == 1'b0, "R7 clean after relock",
            {rx_err, rx_err_sticky}, 0);
    endtask

    task automatic t_idle;
        tx_test_n = 1'b1;
        step();
        chk({tx_drive, tx_rp_n} == 2'b01, "R11 idle drive/strobe", {tx_drive, tx_rp_n}, 2'b01);
        chk({tx_sym_cls, tx_sym_byte} == {2'd1, 8'hBC}, "R11 idle symbol",
            {tx_sym_cls, tx_sym_byte}, {2'd1, 8'hBC});
        tx_viol = 1'b1;
        step();
        chk({tx_sym_cls, tx_sym_byte} == {2'd1, 8'hBC}, "R11 violation ignored when idle",
            {tx_sym_cls, tx_sym_byte}, {2'd1, 8'hBC});
        chk(tx_drive == 1'b0, "R11 drive stays low", tx_drive, 0);
        tx_viol = 1'b0;
    endtask

    initial begin
        t_reset();
        t_alt();
        t_hunt();
        t_loop();
        t_corrupt();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule